// File: doc/BRIEF.md
# Double-Threshold Hit Discriminator

This block watches a stream of signed, digitised pulse samples and decides when a real hit has arrived and at which sample it began. Every valid sample is compared against two programmable levels. The lower level, called the timing level, marks the start of a candidate hit. The upper level, called the confirmation level, must also be reached within a programmable number of later samples before the candidate is accepted. The reported time is the index of the sample that first reached the timing level. This means large and small pulses of the same shape are stamped near the same point on their leading edge. A single high threshold would instead shift the stamp by up to a rise time as the amplitude changes.

Noise that reaches only the timing level is dropped without output. A dropped candidate ends in one of two ways. It may fall back below the timing level, and then the block can start a new candidate at once. It may instead stay up for the whole window, and then the block waits for the signal to fall below the timing level. After an accepted hit the block stays quiet until the signal falls below the timing level again. A polarity input lets the same block handle negative-going pulses by negating each sample before the comparisons. The timestamp comes from a free-running counter of valid samples.

Top module: `dthr_hit_disc`

## Requirements
- R1: While reset is applied and just after its release, `hit_stb` is 0 and `hit_time` is 0. The first valid sample after reset has index 0.
- R2: Each valid sample is indexed by the number of valid samples that came before it since reset, counted modulo 2^TS_W (16 bits by default), so index 65535 is followed by 0.
- R3: A sample reaches a level when its conditioned value is greater than or equal to that level (signed compare). A candidate starts at a sample that reaches `lvl_time` while the block is armed. The candidate is accepted if a later sample reaches `lvl_conf` no more than `win_len` valid samples after it. `hit_stb` is then high for exactly one clock, the clock after the confirming sample is presented.
- R4: On an accepted hit, `hit_time` equals the index of the candidate's starting sample, not that of the confirming sample.
- R5: A sample that reaches both levels while the block is armed is a hit on its own, stamped with its own index. This holds for any `win_len`, including 0.
- R6: A candidate with no confirming sample among the `win_len` following valid samples gives no hit. The block then stays disarmed until a sample falls below `lvl_time`. A confirmation at exactly `win_len` samples after the start is accepted.
- R7: If a sample below `lvl_time` arrives before confirmation, the candidate is dropped without output and the block rearms at once, so the next sample can start a new candidate.
- R8: After an accepted hit, no further hit is produced until a valid sample below `lvl_time` has been seen.
- R9: With `neg_pol` = 1 each sample is negated before both comparisons. A pulse going to -450 then behaves as a positive pulse going to 450, and positive samples do not start candidates.
- R10: Cycles with `smp_valid` = 0 are ignored. Their data does not start, confirm or drop a candidate, and they do not advance the sample index or the window count.
- R11: `hit_time` holds its value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| smp_valid | input | 1 | High when `smp_data` carries a sample this clock |
| smp_data | input | SAMPLE_W | Signed sample value |
| lvl_time | input | SAMPLE_W | Signed timing level (low threshold) |
| lvl_conf | input | SAMPLE_W | Signed confirmation level (high threshold), set at or above `lvl_time` |
| win_len | input | WIN_W | Number of valid samples after the start in which confirmation may arrive |
| neg_pol | input | 1 | 1 to negate samples before comparison (negative pulses) |
| hit_stb | output | 1 | One-clock strobe for an accepted hit |
| hit_time | output | TS_W | Index of the timing-level sample of the latest hit |

## Verification
The bench confirms at exactly `win_len` samples and misses by one sample. A design off by one in its window count would either lose the first pulse or accept the second. It drops a candidate by falling below the timing level and then starts a new one at the very next sample. A design that waits for an extra sample there would report the wrong stamp or no hit. It keeps the signal above the timing level after a hit and brings a second peak. It inserts idle cycles carrying large data into a candidate, runs negative pulses with the polarity set, and uses a zero window. It also runs the index through its wrap. A design that stamped the confirming sample, counted idle cycles or rearmed on the wrong condition would show a wrong timestamp or an unexpected or missing strobe.

// File: rtl/dthr_pkg.sv
package dthr_pkg;
  typedef enum logic [1:0] {
    QS_ARMED = 2'd0,
    QS_WAIT  = 2'd1,
    QS_HOLD  = 2'd2
  } qual_st_t;
endpackage

// File: rtl/dthr_cond.sv
module dthr_cond #(
  parameter int SAMPLE_W = 12
) (
  input  logic signed [SAMPLE_W-1:0]      smp_data,
  input  logic                            neg_pol,
  input  logic        [1:0][SAMPLE_W-1:0] lvls,
  output logic        [1:0]               ge
);
  localparam int EXT_W = SAMPLE_W + 1;

  logic signed [EXT_W-1:0] ext;
  logic signed [EXT_W-1:0] cond;

  assign ext  = $signed({smp_data[SAMPLE_W-1], smp_data});
  assign cond = neg_pol ? -ext : ext;

  for (genvar g = 0; g < 2; g++) begin : g_cmp
    logic signed [EXT_W-1:0] lvl_ext;
    assign lvl_ext = $signed({lvls[g][SAMPLE_W-1], lvls[g]});
    assign ge[g]   = (cond >= lvl_ext);
  end
endmodule

// File: rtl/dthr_tstamp.sv
module dthr_tstamp #(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  output logic [TS_W-1:0] cnt
);
  logic [TS_W-1:0] cnt_q;
  logic [TS_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + {{(TS_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (adv) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/dthr_qual.sv
module dthr_qual
  import dthr_pkg::*;
#(
  parameter int WIN_W = 8,
  parameter int TS_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic             ge_lo,
  input  logic             ge_hi,
  input  logic [WIN_W-1:0] win_len,
  input  logic [TS_W-1:0]  cur_idx,
  output logic             hit_stb,
  output logic [TS_W-1:0]  hit_time
);
  qual_st_t        st_q, st_d;
  logic [WIN_W-1:0] k_q, k_d;
  logic [WIN_W:0]   k_next;
  logic [TS_W-1:0]  ts_q, ts_d;
  logic [TS_W-1:0]  time_q, time_d;
  logic             stb_q, stb_d;

  assign k_next = {1'b0, k_q} + {{WIN_W{1'b0}}, 1'b1};

  always_comb begin
    st_d   = st_q;
    k_d    = k_q;
    ts_d   = ts_q;
    time_d = time_q;
    stb_d  = 1'b0;
    if (smp_valid) begin
      case (st_q)
        QS_ARMED: begin
          if (ge_lo) begin
            ts_d = cur_idx;
            k_d  = '0;
            if (ge_hi) begin
              stb_d  = 1'b1;
              time_d = cur_idx;
              st_d   = QS_HOLD;
            end else if (win_len == '0) begin
              st_d = QS_HOLD;
            end else begin
              st_d = QS_WAIT;
            end
          end
        end
        QS_WAIT: begin
          if (ge_hi) begin
            stb_d  = 1'b1;
            time_d = ts_q;
            st_d   = QS_HOLD;
          end else if (!ge_lo) begin
            st_d = QS_ARMED;
          end else if (k_next >= {1'b0, win_len}) begin
            st_d = QS_HOLD;
          end else begin
            k_d = k_next[WIN_W-1:0];
          end
        end
        QS_HOLD: begin
          if (!ge_lo) begin
            st_d = QS_ARMED;
          end
        end
        default: st_d = QS_ARMED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= QS_ARMED;
      k_q    <= '0;
      ts_q   <= '0;
      time_q <= '0;
    end else if (smp_valid) begin
      st_q   <= st_d;
      k_q    <= k_d;
      ts_q   <= ts_d;
      time_q <= time_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= 1'b0;
    end else begin
      stb_q <= stb_d;
    end
  end

  assign hit_stb  = stb_q;
  assign hit_time = time_q;
endmodule

// File: rtl/dthr_hit_disc.sv
module dthr_hit_disc #(
  parameter int SAMPLE_W = 12,
  parameter int TS_W     = 16,
  parameter int WIN_W    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       smp_valid,
  input  logic signed [SAMPLE_W-1:0] smp_data,
  input  logic signed [SAMPLE_W-1:0] lvl_time,
  input  logic signed [SAMPLE_W-1:0] lvl_conf,
  input  logic        [WIN_W-1:0]    win_len,
  input  logic                       neg_pol,
  output logic                       hit_stb,
  output logic        [TS_W-1:0]     hit_time
);
  logic [1:0][SAMPLE_W-1:0] lvls;
  logic [1:0]               ge;
  logic [TS_W-1:0]          cur_idx;

  assign lvls[0] = lvl_time;
  assign lvls[1] = lvl_conf;

  dthr_cond #(.SAMPLE_W(SAMPLE_W)) u_cond (
    .smp_data (smp_data),
    .neg_pol  (neg_pol),
    .lvls     (lvls),
    .ge       (ge)
  );

  dthr_tstamp #(.TS_W(TS_W)) u_tstamp (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (smp_valid),
    .cnt   (cur_idx)
  );

  dthr_qual #(.WIN_W(WIN_W), .TS_W(TS_W)) u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .ge_lo     (ge[0]),
    .ge_hi     (ge[1]),
    .win_len   (win_len),
    .cur_idx   (cur_idx),
    .hit_stb   (hit_stb),
    .hit_time  (hit_time)
  );
endmodule

// File: rtl/dthr_chk.sv
module dthr_chk #(
  parameter int SAMPLE_W = 12,
  parameter int TS_W     = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       smp_valid,
  input logic signed [SAMPLE_W-1:0] smp_data,
  input logic signed [SAMPLE_W-1:0] lvl_conf,
  input logic                       neg_pol,
  input logic                       hit_stb,
  input logic        [TS_W-1:0]     hit_time
);
  logic signed [SAMPLE_W:0] c_ext;
  logic signed [SAMPLE_W:0] c_val;
  logic signed [SAMPLE_W:0] c_hi;
  logic                     c_reach_hi;

  assign c_ext      = $signed({smp_data[SAMPLE_W-1], smp_data});
  assign c_val      = neg_pol ? -c_ext : c_ext;
  assign c_hi       = $signed({lvl_conf[SAMPLE_W-1], lvl_conf});
  assign c_reach_hi = smp_valid && (c_val >= c_hi);

  AST_HIT_NEEDS_CONF: assert property (@(posedge clk) disable iff (!rst_n)
    hit_stb |-> $past(c_reach_hi)); // R3

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_stb |=> !hit_stb); // R8

  AST_TIME_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_stb |-> $stable(hit_time)); // R11

  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> !hit_stb); // R10
endmodule

bind dthr_hit_disc dthr_chk #(.SAMPLE_W(SAMPLE_W), .TS_W(TS_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_valid (smp_valid),
  .smp_data  (smp_data),
  .lvl_conf  (lvl_conf),
  .neg_pol   (neg_pol),
  .hit_stb   (hit_stb),
  .hit_time  (hit_time)
);

// File: tb/test_dthr_hit_disc.sv
`timescale 1ns/1ps
module test_dthr_hit_disc;
  localparam int SAMPLE_W = 12;
  localparam int TS_W     = 16;
  localparam int WIN_W    = 8;

  logic                       clk;
  logic                       rst_n;
  logic                       smp_valid;
  logic signed [SAMPLE_W-1:0] smp_data;
  logic signed [SAMPLE_W-1:0] lvl_time;
  logic signed [SAMPLE_W-1:0] lvl_conf;
  logic        [WIN_W-1:0]    win_len;
  logic                       neg_pol;
  logic                       hit_stb;
  logic        [TS_W-1:0]     hit_time;

  dthr_hit_disc #(.SAMPLE_W(SAMPLE_W), .TS_W(TS_W), .WIN_W(WIN_W)) i_dthr_hit_disc (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .lvl_time(lvl_time), .lvl_conf(lvl_conf), .win_len(win_len),
    .neg_pol(neg_pol), .hit_stb(hit_stb), .hit_time(hit_time)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int pushed = 0;
  int seen   = 0;
  bit done   = 0;
  logic [TS_W-1:0] idx = '0;
  logic [TS_W-1:0] x;
  logic [TS_W-1:0] exp_q[$];
  string           tag_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && hit_stb) begin
      seen++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6/R8 unexpected hit", int'(hit_time), -1);
      end else begin
        logic [TS_W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(hit_time == e, t, int'(hit_time), int'(e));
      end
    end
  end

  task automatic send(input int v);
    smp_data  = SAMPLE_W'(v);
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
    idx = idx + 1'b1;
  endtask

  task automatic send_hit(input int v, input logic [TS_W-1:0] ts, input string tag);
    exp_q.push_back(ts);
    tag_q.push_back(tag);
    pushed++;
    send(v);
    chk(hit_stb == 1'b1, {tag, " strobe timing"}, int'(hit_stb), 1);
  endtask

  task automatic idle(input int n, input int v);
    smp_valid = 1'b0;
    smp_data  = SAMPLE_W'(v);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_count(input string tag);
    chk(seen == pushed, tag, seen, pushed);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; smp_valid = 1'b0; smp_data = '0;
    lvl_time = 12'sd100; lvl_conf = 12'sd400; win_len = 8'd3; neg_pol = 1'b0;
    repeat (3) @(negedge clk);
    chk(hit_stb == 1'b0, "R1 strobe in reset", int'(hit_stb), 0);
    chk(hit_time == '0, "R1 time in reset", int'(hit_time), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(hit_stb == 1'b0, "R1 strobe after reset", int'(hit_stb), 0);
    chk(hit_time == '0, "R1 time after reset", int'(hit_time), 0);

    // R2 R3 R4: confirmation two samples after start
    send(0); send(0);
    x = idx; send(150); send(250); send_hit(450, x, "R4 stamp of timing sample");
    send(0);
    // R5 same-sample
    send(0); x = idx; send_hit(500, x, "R5 both levels in one sample");
    send(0);
    // R6 boundary accepted at win_len
    x = idx; send(150); send(200); send(200); send_hit(450, x, "R6 confirm at window edge");
    send(0);
    // R6 one sample late
    send(150); send(200); send(200); send(200); send(450); send(450); send(50);
    check_count("R6 late confirmation dropped");
    // R7 drop and immediate rearm
    send(150); send(50); x = idx; send(160); send_hit(420, x, "R7 rearm after fall");
    send(0);
    // R8 no second hit while above timing level
    x = idx; send_hit(500, x, "R8 first peak");
    send(450); send(300); send(600);
    check_count("R8 second peak suppressed");
    send(50); x = idx; send_hit(600, x, "R8 hit after fall");
    send(0);
    // R10 idle cycles ignored
    x = idx; send(150); idle(3, 900);
    check_count("R10 idle data ignored");
    send_hit(450, x, "R10 idle not indexed");
    send(0);
    // R11 held
    idle(4, 0);
    chk(hit_time == x, "R11 time held", int'(hit_time), int'(x));
    // R9 negative polarity
    neg_pol = 1'b1;
    send(500); send(150);
    check_count("R9 positive ignored");
    send(0);
    x = idx; send(-150); send_hit(-450, x, "R9 negative pulse");
    send(0);
    neg_pol = 1'b0;
    // zero window
    win_len = 8'd0;
    send(150); send(450);
    check_count("R6 zero window no confirm");
    send(0); x = idx; send_hit(450, x, "R5 zero window single sample");
    send(0);
    win_len = 8'd3;
    // R2 wrap
    while (idx != 16'hFFFE) send(0);
    x = idx; send(150); send_hit(450, x, "R2 index near wrap");
    send(0);
    x = idx; send_hit(500, x, "R2 index after wrap");
    chk(x == 16'd1, "R2 wrapped index", int'(x), 1);
    send(0);
    idle(3, 0);
    check_count("R3 all hits seen");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule